// File: doc/BRIEF.md
# SEC-DED Hamming Codec

This block protects a stored data word with a single-error-correcting, double-error-detecting code. The encoder side takes a data word and returns a stored word. That stored word holds the data, a set of Hamming check bits and one overall parity bit. The decoder side takes a stored word as it comes back from storage and recomputes the check bits from it. The stored and recomputed check bits combine into a syndrome. From the syndrome and the overall parity, the decoder classifies the word as clean, as a correctable single error, or as an uncorrectable double error. It then returns the data with the single flipped bit repaired.

The stored word is laid out by position. Bit 0 of the stored word holds the overall parity bit. Bit p, for p from 1 to DATA_W+CHK_W, holds codeword position p. Check bits sit at the power-of-two positions, so a nonzero syndrome is the position of the bit that flipped. A correction-enable input lets the raw data pass while the flags are still reported. The encoder is purely combinational.

The decoder result passes through an optional output register, selected by `REG_OUT` (default on). With the register on, results appear one clock after the input is presented. The decoder path carries a valid bit alongside the data but has no ready signal. A word is accepted on every cycle that `dec_in_valid` is high, and the consumer cannot stall the block, so there is no back-pressure.

Top module: `secded_codec`

## Requirements
- R1: The number of check bits CHK_W is the smallest value with DATA_W + CHK_W + 1 <= 2^CHK_W. The stored word has DATA_W + CHK_W + 1 bits (13 for 8 data bits, 72 for 64). Bit 0 holds the overall parity bit. Bit p >= 1 holds codeword position p. Check bit k (k = 1..CHK_W) sits at position 2^(k-1). Data bit i fills the non-power-of-two positions in ascending order, so with 8 data bits, data bits 0..7 sit at positions 3, 5, 6, 7, 9, 10, 11, 12.
- R2: Check bit k is the XOR of the data bits whose position index has binary bit k-1 set. For 8 data bits: check1 = d0^d1^d3^d4^d6, check2 = d0^d2^d3^d5^d6, check3 = d1^d2^d3^d7, check4 = d4^d5^d6^d7.
- R3: The overall parity bit is the XOR of every position 1..DATA_W+CHK_W, so an encoded word always has an even number of ones.
- R4: `dec_syndrome` is the XOR of the stored check bits with the check bits recomputed from the received data. For a single flipped position p, it equals p.
- R5: With correction enabled, a single flipped data position gives `dec_single`=1 and `dec_double`=0, and `dec_data` equals the originally encoded data.
- R6: A single flip on a check-bit position gives `dec_single`=1 and leaves `dec_data` unchanged. A flip of the overall parity bit (bit 0) does the same, with a syndrome of 0.
- R7: Two flipped positions give `dec_double`=1 and `dec_single`=0, and `dec_data` is not modified. For example, flipping positions 6 and 10 gives syndrome 12, and the data bit at position 12 must stay as received.
- R8: A syndrome greater than DATA_W+CHK_W combined with an overall parity error is reported as `dec_double`=1 and changes no data bit.
- R9: With `dec_fix_en`=0, `dec_data` is the received data bits unchanged, while `dec_single`, `dec_double` and `dec_syndrome` are reported as with correction on.
- R10: With `REG_OUT`=1, `dec_out_valid` equals `dec_in_valid` delayed by one clock, and the data, syndrome and flags follow with the same latency. `dec_single` and `dec_double` are only ever high together with `dec_out_valid`, and never both at once.
- R11: While `rst_n` is low (asynchronous, active low), `dec_out_valid`, `dec_single`, `dec_double`, `dec_data` and `dec_syndrome` are all 0.
- R12: An unmodified encoded word gives syndrome 0, no flags, and the original data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_data | input | DATA_W | Data word to encode |
| enc_word | output | DATA_W+CHK_W+1 | Encoded stored word (bit 0 overall parity) |
| dec_in_valid | input | 1 | Received word on `dec_word` is valid |
| dec_word | input | DATA_W+CHK_W+1 | Received stored word |
| dec_fix_en | input | 1 | Enables correction of a single data-bit error |
| dec_out_valid | output | 1 | Decoder result is valid |
| dec_data | output | DATA_W | Decoded (optionally corrected) data |
| dec_syndrome | output | CHK_W | Syndrome: stored XOR recomputed check bits |
| dec_single | output | 1 | Correctable single error detected |
| dec_double | output | 1 | Uncorrectable error detected |

## Verification
The assertions hold several relations on every cycle. Encoded words must have even parity. The two error flags are mutually exclusive and never rise without a valid result. A zero syndrome is never classed as a double error, and an out-of-range syndrome is always classed as one. The valid bit must track its input through the register stage. Only the bench's scenarios can show that the check bits match the stated equations and that the syndrome names the flipped position. The same holds for repairing the right data bit, leaving data alone on check-bit hits, double errors and disabled correction, and clearing the outputs on reset.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // Smallest check-bit count h such that dw + h + 1 <= 2^h.
  function automatic int chk_width(input int dw);
    for (int h = 1; h < 31; h++) begin
      if ((dw + h + 1) <= (1 << h)) return h;
    end
    return 31;
  endfunction

  function automatic bit is_pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // Codeword position (1-based) of data bit i: i-th non-power-of-two index.
  function automatic int data_pos(input int i);
    int cnt;
    cnt = 0;
    for (int p = 1; p < 65536; p++) begin
      if (!is_pow2(p)) begin
        if (cnt == i) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

  typedef enum logic [1:0] {
    CLS_CLEAN  = 2'd0,
    CLS_SINGLE = 2'd1,
    CLS_DOUBLE = 2'd2
  } err_class_e;

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder #(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 7,
  localparam int WORD_W = DATA_W + CHK_W + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o
);

  // Mask of data positions covered by check bit k (index bit k set).
  function automatic logic [WORD_W-1:0] cover_mask(input int k);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int p = 1; p < WORD_W; p++) begin
      if (!secded_pkg::is_pow2(p) && ((p >> k) & 1) == 1) m[p] = 1'b1;
    end
    return m;
  endfunction

  logic [WORD_W-1:0] placed;  // data only, zeros elsewhere
  logic [WORD_W-1:0] body;    // data plus check bits, bit 0 zero

  assign placed[0] = 1'b0;
  assign body[0]   = 1'b0;

  for (genvar i = 0; i < DATA_W; i++) begin : g_place
    localparam int POS = secded_pkg::data_pos(i);
    assign placed[POS] = data_i[i];
    assign body[POS]   = data_i[i];
  end

  for (genvar k = 0; k < CHK_W; k++) begin : g_check
    localparam int POS = 1 << k;
    assign placed[POS] = 1'b0;
    assign body[POS]   = ^(placed & cover_mask(k));
  end

  assign word_o = {body[WORD_W-1:1], ^body};

endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome #(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 7,
  localparam int WORD_W = DATA_W + CHK_W + 1
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [CHK_W-1:0]  syn_o,
  output logic              perr_o,
  output logic [DATA_W-1:0] data_raw_o
);

  // All positions (data and check) whose index has bit k set; XOR over
  // them equals stored check bit k XOR the recomputed one.
  function automatic logic [WORD_W-1:0] pos_mask(input int k);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int p = 1; p < WORD_W; p++) begin
      if (((p >> k) & 1) == 1) m[p] = 1'b1;
    end
    return m;
  endfunction

  for (genvar k = 0; k < CHK_W; k++) begin : g_syn
    assign syn_o[k] = ^(word_i & pos_mask(k));
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_pick
    assign data_raw_o[i] = word_i[secded_pkg::data_pos(i)];
  end

  assign perr_o = ^word_i;

endmodule

// File: rtl/secded_fix.sv
module secded_fix #(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 7,
  localparam int LAST_POS = DATA_W + CHK_W
) (
  input  logic [DATA_W-1:0]          data_raw_i,
  input  logic [CHK_W-1:0]           syn_i,
  input  logic                       perr_i,
  input  logic                       fix_en_i,
  output logic [DATA_W-1:0]          data_o,
  output secded_pkg::err_class_e     cls_o
);

  logic do_fix;

  always_comb begin
    if (syn_i == '0 && !perr_i) begin
      cls_o = secded_pkg::CLS_CLEAN;
    end else if (perr_i && (syn_i <= CHK_W'(LAST_POS))) begin
      cls_o = secded_pkg::CLS_SINGLE;
    end else begin
      cls_o = secded_pkg::CLS_DOUBLE;
    end
  end

  assign do_fix = fix_en_i && (cls_o == secded_pkg::CLS_SINGLE);

  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    localparam int POS = secded_pkg::data_pos(i);
    assign data_o[i] = data_raw_i[i] ^ (do_fix && (syn_i == CHK_W'(POS)));
  end

endmodule

// File: rtl/secded_codec.sv
module secded_codec #(
  parameter int DATA_W  = 64,
  parameter bit REG_OUT = 1'b1,
  localparam int CHK_W  = secded_pkg::chk_width(DATA_W),
  localparam int WORD_W = DATA_W + CHK_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] enc_data,
  output logic [WORD_W-1:0] enc_word,
  input  logic              dec_in_valid,
  input  logic [WORD_W-1:0] dec_word,
  input  logic              dec_fix_en,
  output logic              dec_out_valid,
  output logic [DATA_W-1:0] dec_data,
  output logic [CHK_W-1:0]  dec_syndrome,
  output logic              dec_single,
  output logic              dec_double
);

  logic [CHK_W-1:0]       syn_c;
  logic                   perr_c;
  logic [DATA_W-1:0]      raw_c;
  logic [DATA_W-1:0]      data_c;
  secded_pkg::err_class_e cls_c;
  logic                   single_c;
  logic                   double_c;

  secded_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
    .data_i (enc_data),
    .word_o (enc_word)
  );

  secded_syndrome #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_syn (
    .word_i     (dec_word),
    .syn_o      (syn_c),
    .perr_o     (perr_c),
    .data_raw_o (raw_c)
  );

  secded_fix #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_fix (
    .data_raw_i (raw_c),
    .syn_i      (syn_c),
    .perr_i     (perr_c),
    .fix_en_i   (dec_fix_en),
    .data_o     (data_c),
    .cls_o      (cls_c)
  );

  assign single_c = dec_in_valid && (cls_c == secded_pkg::CLS_SINGLE);
  assign double_c = dec_in_valid && (cls_c == secded_pkg::CLS_DOUBLE);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dec_out_valid <= 1'b0;
        dec_data      <= '0;
        dec_syndrome  <= '0;
        dec_single    <= 1'b0;
        dec_double    <= 1'b0;
      end else begin
        dec_out_valid <= dec_in_valid;
        dec_data      <= data_c;
        dec_syndrome  <= syn_c;
        dec_single    <= single_c;
        dec_double    <= double_c;
      end
    end
  end else begin : g_comb
    assign dec_out_valid = dec_in_valid;
    assign dec_data      = data_c;
    assign dec_syndrome  = syn_c;
    assign dec_single    = single_c;
    assign dec_double    = double_c;
  end

endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk #(
  parameter int DATA_W  = 64,
  parameter bit REG_OUT = 1'b1,
  localparam int CHK_W  = secded_pkg::chk_width(DATA_W),
  localparam int WORD_W = DATA_W + CHK_W + 1,
  localparam int LAST_POS = DATA_W + CHK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] enc_word,
  input logic              dec_in_valid,
  input logic              dec_out_valid,
  input logic [CHK_W-1:0]  dec_syndrome,
  input logic              dec_single,
  input logic              dec_double
);

  AST_ENC_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (^enc_word) == 1'b0); // R3

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_single && dec_double)); // R10

  AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_single || dec_double) |-> dec_out_valid); // R10

  AST_ZERO_SYN_NOT_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && dec_syndrome == '0) |-> !dec_double); // R6

  AST_SYN_RANGE_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && dec_syndrome > CHK_W'(LAST_POS)) |-> dec_double); // R8

  if (REG_OUT) begin : g_pipe
    AST_VALID_RISE_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      dec_in_valid |=> dec_out_valid); // R10
    AST_VALID_FALL_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_in_valid |=> !dec_out_valid); // R10
  end else begin : g_thru
    AST_VALID_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      dec_out_valid == dec_in_valid); // R10
  end

endmodule

bind secded_codec secded_codec_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .enc_word      (enc_word),
  .dec_in_valid  (dec_in_valid),
  .dec_out_valid (dec_out_valid),
  .dec_syndrome  (dec_syndrome),
  .dec_single    (dec_single),
  .dec_double    (dec_double)
);

// File: tb/test_secded_codec.sv
`timescale 1ns/1ps
module test_secded_codec;

  localparam int DW = 8;
  localparam int HW = 4;
  localparam int WW = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] enc_data = '0;
  logic [WW-1:0] enc_word;
  logic          dec_in_valid = 1'b0;
  logic [WW-1:0] dec_word = '0;
  logic          dec_fix_en = 1'b1;
  logic          dec_out_valid;
  logic [DW-1:0] dec_data;
  logic [HW-1:0] dec_syndrome;
  logic          dec_single;
  logic          dec_double;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  secded_codec #(.DATA_W(DW), .REG_OUT(1'b1)) i_secded_codec (
    .clk(clk), .rst_n(rst_n), .enc_data(enc_data), .enc_word(enc_word),
    .dec_in_valid(dec_in_valid), .dec_word(dec_word), .dec_fix_en(dec_fix_en),
    .dec_out_valid(dec_out_valid), .dec_data(dec_data), .dec_syndrome(dec_syndrome),
    .dec_single(dec_single), .dec_double(dec_double)
  );

  // Reference encoding from the stated check equations (R1, R2, R3).
  function automatic logic [WW-1:0] ref_enc(input logic [DW-1:0] d);
    logic c1, c2, c3, c4;
    logic [WW-1:0] w;
    c1 = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    c2 = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    c3 = d[1] ^ d[2] ^ d[3] ^ d[7];
    c4 = d[4] ^ d[5] ^ d[6] ^ d[7];
    w = {d[7], d[6], d[5], d[4], c4, d[3], d[2], d[1], c3, d[0], c2, c1, 1'b0};
    w[0] = ^w[WW-1:1];
    return w;
  endfunction

  function automatic int dpos(input int i);
    case (i)
      0: return 3;  1: return 5;  2: return 6;  3: return 7;
      4: return 9;  5: return 10; 6: return 11; default: return 12;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive_dec(input logic [WW-1:0] w, input logic fix, input logic vld);
    @(negedge clk);
    dec_word = w;
    dec_fix_en = fix;
    dec_in_valid = vld;
    @(negedge clk);
  endtask

  task automatic check_dec(input string req, input logic [DW-1:0] d,
                           input logic [HW-1:0] syn, input logic s, input logic dd);
    check(req, "valid", {31'd0, dec_out_valid}, 32'd1);
    check(req, "data", {24'd0, dec_data}, {24'd0, d});
    check(req, "syndrome", {28'd0, dec_syndrome}, {28'd0, syn});
    check(req, "single", {31'd0, dec_single}, {31'd0, s});
    check(req, "double", {31'd0, dec_double}, {31'd0, dd});
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    check("R11", "valid in reset", {31'd0, dec_out_valid}, 32'd0);
    check("R11", "single in reset", {31'd0, dec_single}, 32'd0);
    check("R11", "double in reset", {31'd0, dec_double}, 32'd0);
    check("R11", "data in reset", {24'd0, dec_data}, 32'd0);
  endtask

  task automatic t_encode;
    logic [DW-1:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h01, 8'h80, 8'h3C};
    foreach (pats[n]) begin
      @(negedge clk);
      enc_data = pats[n];
      #1;
      check("R2", "enc word", {19'd0, enc_word}, {19'd0, ref_enc(pats[n])});
      check("R3", "enc parity", {31'd0, ^enc_word}, 32'd0);
    end
  endtask

  task automatic t_clean;
    logic [DW-1:0] pats [3] = '{8'h00, 8'hC3, 8'h5A};
    foreach (pats[n]) begin
      drive_dec(ref_enc(pats[n]), 1'b1, 1'b1);
      check_dec("R12", pats[n], 4'd0, 1'b0, 1'b0);
    end
  endtask

  task automatic t_single_data;
    for (int i = 0; i < DW; i++) begin
      logic [WW-1:0] w;
      w = ref_enc(8'h96);
      w[dpos(i)] = ~w[dpos(i)];
      drive_dec(w, 1'b1, 1'b1);
      check_dec("R4 R5", 8'h96, 4'(dpos(i)), 1'b1, 1'b0);
    end
  endtask

  task automatic t_check_bits;
    int cpos [5] = '{1, 2, 4, 8, 0};
    foreach (cpos[n]) begin
      logic [WW-1:0] w;
      w = ref_enc(8'h4E);
      w[cpos[n]] = ~w[cpos[n]];
      drive_dec(w, 1'b1, 1'b1);
      check_dec("R6", 8'h4E, 4'(cpos[n]), 1'b1, 1'b0);
    end
  endtask

  task automatic t_double;
    logic [WW-1:0] w;
    w = ref_enc(8'h00);
    w[6] = ~w[6];
    w[10] = ~w[10];
    drive_dec(w, 1'b1, 1'b1);
    check_dec("R7", 8'h24, 4'd12, 1'b0, 1'b1);  // received d2,d5 set; d7 untouched
  endtask

  task automatic t_beyond;
    logic [WW-1:0] w;
    w = ref_enc(8'h71);
    w[1] = ~w[1]; w[4] = ~w[4]; w[8] = ~w[8];
    drive_dec(w, 1'b1, 1'b1);
    check_dec("R8", 8'h71, 4'd13, 1'b0, 1'b1);
    w = ref_enc(8'h71);
    w[3] = ~w[3]; w[4] = ~w[4]; w[8] = ~w[8];
    drive_dec(w, 1'b1, 1'b1);
    check_dec("R8", 8'h70, 4'd15, 1'b0, 1'b1);
  endtask

  task automatic t_nofix;
    logic [WW-1:0] w;
    w = ref_enc(8'hB2);
    w[11] = ~w[11];
    drive_dec(w, 1'b0, 1'b1);
    check_dec("R9", 8'hF2, 4'd11, 1'b1, 1'b0);
  endtask

  task automatic t_valid;
    logic [WW-1:0] w;
    w = ref_enc(8'h11);
    w[5] = ~w[5];
    w[9] = ~w[9];
    drive_dec(w, 1'b1, 1'b0);
    check("R10", "valid low", {31'd0, dec_out_valid}, 32'd0);
    check("R10", "double gated", {31'd0, dec_double}, 32'd0);
    @(negedge clk);
    dec_in_valid = 1'b1;
    #1;
    check("R10", "no early valid", {31'd0, dec_out_valid}, 32'd0);
    @(negedge clk);
    check("R10", "valid after one clock", {31'd0, dec_out_valid}, 32'd1);
    check("R10", "double after one clock", {31'd0, dec_double}, 32'd1);
  endtask

  task automatic t_mid_reset;
    logic [WW-1:0] w;
    w = ref_enc(8'hE7);
    w[2] = ~w[2];
    drive_dec(w, 1'b1, 1'b1);
    check("R11", "single before reset", {31'd0, dec_single}, 32'd1);
    rst_n = 1'b0;
    #1;
    check("R11", "valid cleared", {31'd0, dec_out_valid}, 32'd0);
    check("R11", "single cleared", {31'd0, dec_single}, 32'd0);
    check("R11", "syndrome cleared", {28'd0, dec_syndrome}, 32'd0);
    check("R11", "data cleared", {24'd0, dec_data}, 32'd0);
    dec_in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin : main
    t_reset_state();
    @(negedge clk);
    rst_n = 1'b1;
    t_encode();
    t_clean();
    t_single_data();
    t_check_bits();
    t_double();
    t_beyond();
    t_nofix();
    t_valid();
    t_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule